// File: doc/BRIEF.md
# Sampling converter conversion control and bus interface

This block sits between a host bus and a parallel-output sampling converter core. The host starts a conversion by pulling the sample/hold line low while chip-select is asserted. The block then sends a single-cycle start pulse to the core and waits for the core's done strobe. When the strobe arrives it captures the result word into a holding register, raises end-of-conversion and asserts an active-low interrupt. A read falling edge clears the interrupt.

Two bus modes are supported. In interrupt/read mode the data outputs are enabled only while chip-select and read are both low. In high-speed mode the held result is driven onto the bus continuously, so the host does not have to wait between interrupt and read. All host-side control inputs are asynchronous and pass through two-stage synchronizers before any edge is detected. A sample/hold request that arrives while a conversion is already running is dropped and recorded in a sticky overrun flag.

Top module: `adc_host_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released: endOfConv=1, intN=1, overrun=0, convStart=0, dataOut=0, and dataOe=0 when fastMode=0.
- R2: A falling edge on shN while csN is low, and no conversion running, gives convStart=1 for exactly one clock, on the third rising clock edge after the input change. endOfConv goes to 0 on that same edge.
- R3: A convDone=1 sampled while a conversion runs captures convResult into dataOut, sets endOfConv=1 and drives intN=0, all on that clock edge.
- R4: dataOut keeps the previous result from the start pulse until the new result is captured.
- R5: A falling edge on rdN while csN is low sets intN=1 on the third rising edge after the input change.
- R6: While csN is high, shN and rdN edges have no effect: no start pulse, and intN and endOfConv keep their values.
- R7: With fastMode=0, dataOe equals 1 exactly when the synchronized csN and rdN are both low. The latency is three rising edges after the input change.
- R8: With fastMode=1, dataOe is 1 regardless of csN and rdN, three rising edges after fastMode rises.
- R9: An shN falling edge with csN low during a running conversion produces no start pulse. It sets overrun=1, which stays set until reset.
- R10: A convDone pulse while no conversion runs changes neither dataOut, endOfConv nor intN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip-select (asynchronous) |
| shN | input | 1 | Sample/hold control; a falling edge starts a conversion (asynchronous) |
| rdN | input | 1 | Active-low read (asynchronous) |
| fastMode | input | 1 | 1 = high-speed mode, 0 = interrupt/read mode (asynchronous) |
| convDone | input | 1 | One-cycle done strobe from the converter core |
| convResult | input | DATA_W | Result word from the converter core, valid with convDone |
| convStart | output | 1 | One-cycle start pulse to the converter core |
| endOfConv | output | 1 | High when the last conversion has completed |
| intN | output | 1 | Active-low interrupt, set on completion and cleared by a read |
| dataOut | output | DATA_W | Held result word |
| dataOe | output | 1 | Enable for the external tri-state data drivers |
| overrun | output | 1 | Sticky flag: a start request was dropped during a conversion |

## Verification
If the busy state is wrong, it shows at the ports within one conversion. A stuck-busy block gives no start pulse for the next shN edge and sets overrun spuriously. A stuck-idle block gives a second convStart for a request made mid-conversion. A wrong edge detector or synchronizer depth moves convStart, intN or dataOe off the third rising edge, which the bench samples exactly. A bad capture path shows as a wrong dataOut on the cycle after convDone. The bench sweeps every 12-bit result value through a full start, done and read cycle.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

  // Strobes from the control section to the datapath
  typedef struct packed {
    logic capture;   // load the core result into the holding register
    logic driveBus;  // request the bus drivers to be enabled
  } dpStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } convState_t;

endpackage

// File: rtl/adc_host_sync.sv
module adc_host_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= RST_VAL;
    else       stage[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[i] <= RST_VAL;
      else       stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/adc_host_ctl.sv
module adc_host_ctl
  import adc_host_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csS,
  input  logic       shS,
  input  logic       rdS,
  input  logic       fastS,
  input  logic       convDone,
  output logic       convStart,
  output logic       endOfConv,
  output logic       intN,
  output logic       overrun,
  output logic       rdFall,
  output dpStrobe_t  strobe
);

  convState_t state;
  logic shPrev;
  logic rdPrev;
  logic shFall;
  logic finishing;

  // Edge detection on synchronized inputs, gated by chip-select
  assign shFall = shPrev & ~shS & ~csS;
  assign rdFall = rdPrev & ~rdS & ~csS;
  assign finishing = (state == ST_BUSY) & convDone;

  assign strobe.capture  = finishing;
  assign strobe.driveBus = fastS | (~csS & ~rdS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shPrev <= 1'b1;
      rdPrev <= 1'b1;
    end else begin
      shPrev <= shS;
      rdPrev <= rdS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      convStart <= 1'b0;
      endOfConv <= 1'b1;
      intN      <= 1'b1;
      overrun   <= 1'b0;
    end else begin
      convStart <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (shFall) begin
            state     <= ST_BUSY;
            convStart <= 1'b1;
            endOfConv <= 1'b0;
          end
        end
        ST_BUSY: begin
          if (shFall) overrun <= 1'b1;
          if (convDone) begin
            state     <= ST_IDLE;
            endOfConv <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
      // A fresh result takes priority over a read in the same cycle
      if (finishing)   intN <= 1'b0;
      else if (rdFall) intN <= 1'b1;
    end
  end

endmodule

// File: rtl/adc_host_dp.sv
module adc_host_dp
  import adc_host_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] convResult,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
      dataOe  <= 1'b0;
    end else begin
      if (strobe.capture) dataOut <= convResult;
      dataOe <= strobe.driveBus;
    end
  end

endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
  import adc_host_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              shN,
  input  logic              rdN,
  input  logic              fastMode,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convResult,
  output logic              convStart,
  output logic              endOfConv,
  output logic              intN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              overrun
);

  localparam int NUM_SYNC = 4;
  localparam logic [NUM_SYNC-1:0] SYNC_RST = 4'b0111; // fast=0, rd/sh/cs idle high

  logic [NUM_SYNC-1:0] syncIn;
  logic [NUM_SYNC-1:0] syncOut;
  logic csS, shS, rdS, fastS;
  logic rdFall;
  dpStrobe_t strobe;

  assign syncIn = {fastMode, rdN, shN, csN};
  assign {fastS, rdS, shS, csS} = syncOut;

  adc_host_sync #(
    .WIDTH(NUM_SYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk(clk), .rstN(rstN), .din(syncIn), .dout(syncOut)
  );

  adc_host_ctl u_ctl (
    .clk(clk), .rstN(rstN),
    .csS(csS), .shS(shS), .rdS(rdS), .fastS(fastS),
    .convDone(convDone),
    .convStart(convStart), .endOfConv(endOfConv), .intN(intN),
    .overrun(overrun), .rdFall(rdFall), .strobe(strobe)
  );

  adc_host_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .convResult(convResult), .dataOut(dataOut), .dataOe(dataOe)
  );

endmodule

// File: rtl/adc_host_chk.sv
module adc_host_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              convStart,
  input logic              endOfConv,
  input logic              intN,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe,
  input logic              overrun,
  input logic              rdFall,
  input logic              fastS
);

  p_single_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  p_eoc_low_on_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> !endOfConv);

  p_done_flags_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(endOfConv) |-> !intN);

  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !endOfConv |-> $stable(dataOut));

  p_int_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intN) |-> $past(rdFall));

  p_fast_oe_r8: assert property (@(posedge clk) disable iff (!rstN)
    fastS |=> dataOe);

  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

endmodule

bind adc_host_ctrl adc_host_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .convStart(convStart), .endOfConv(endOfConv),
  .intN(intN), .dataOut(dataOut), .dataOe(dataOe), .overrun(overrun),
  .rdFall(rdFall), .fastS(fastS)
);

// File: tb/adc_host_ctrl_bench.sv
`timescale 1ns/1ps
module adc_host_ctrl_bench;

  localparam int DATA_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, shN = 1'b1, rdN = 1'b1, fastMode = 1'b0;
  logic convDone = 1'b0;
  logic [DATA_W-1:0] convResult = '0;
  logic convStart, endOfConv, intN, dataOe, overrun;
  logic [DATA_W-1:0] dataOut;

  int nVec = 0;
  int nBad = 0;
  logic [DATA_W-1:0] lastVal = '0;

  always #5 clk = ~clk;

  adc_host_ctrl #(.DATA_W(DATA_W)) u_adc_host_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .shN(shN), .rdN(rdN),
    .fastMode(fastMode), .convDone(convDone), .convResult(convResult),
    .convStart(convStart), .endOfConv(endOfConv), .intN(intN),
    .dataOut(dataOut), .dataOe(dataOe), .overrun(overrun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Starts a conversion (csN low assumed) and checks the start timing
  task automatic startConv();
    shN = 1'b0;
    tick(2);
    chk("R2 start too early", convStart, 0);
    tick(1);
    chk("R2 start pulse", convStart, 1);
    chk("R2 eoc low on start", endOfConv, 0);
    chk("R4 data held at start", dataOut, lastVal);
    shN = 1'b1;
    tick(1);
    chk("R2 single pulse", convStart, 0);
  endtask

  task automatic finishConv(input logic [DATA_W-1:0] v, input int lat);
    tick(lat);
    chk("R4 data held in flight", dataOut, lastVal);
    convResult = v;
    convDone = 1'b1;
    tick(1);
    convDone = 1'b0;
    chk("R3 data captured", dataOut, v);
    chk("R3 eoc high", endOfConv, 1);
    chk("R3 int asserted", intN, 0);
    lastVal = v;
  endtask

  task automatic readOut();
    rdN = 1'b0;
    tick(2);
    chk("R5 int not yet cleared", intN, 0);
    tick(1);
    chk("R5 int cleared", intN, 1);
    chk("R7 oe on read", dataOe, 1);
    rdN = 1'b1;
    tick(3);
    chk("R7 oe off after read", dataOe, 0);
  endtask

  initial begin
    tick(3);
    chk("R1 eoc in reset", endOfConv, 1);
    chk("R1 int in reset", intN, 1);
    chk("R1 overrun in reset", overrun, 0);
    chk("R1 start in reset", convStart, 0);
    chk("R1 data in reset", dataOut, 0);
    chk("R1 oe in reset", dataOe, 0);
    rstN = 1'b1;
    tick(2);
    chk("R1 eoc after reset", endOfConv, 1);
    chk("R1 int after reset", intN, 1);
    chk("R1 oe after reset", dataOe, 0);
    csN = 1'b0;
    tick(3);
    chk("R7 oe with rd high", dataOe, 0);

    // R10: stray done while idle
    convResult = 12'hABC;
    convDone = 1'b1;
    tick(1);
    convDone = 1'b0;
    chk("R10 data untouched", dataOut, 0);
    chk("R10 int untouched", intN, 1);
    chk("R10 eoc untouched", endOfConv, 1);

    // Sweep every result value through start/done/read
    for (int v = 0; v < (1 << DATA_W); v++) begin
      startConv();
      finishConv(v[DATA_W-1:0], v % 4);
      readOut();
    end

    // R9: request during a conversion
    startConv();
    tick(2);
    shN = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick(1);
      chk("R9 no second start", convStart, 0);
    end
    chk("R9 overrun set", overrun, 1);
    chk("R9 eoc still low", endOfConv, 0);
    shN = 1'b1;
    finishConv(12'h5A5, 1);
    tick(3);
    chk("R9 overrun sticky", overrun, 1);
    readOut();

    // R6: chip-select high blocks sample/hold
    csN = 1'b1;
    tick(3);
    shN = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick(1);
      chk("R6 sh ignored start", convStart, 0);
      chk("R6 sh ignored eoc", endOfConv, 1);
    end
    shN = 1'b1;
    tick(3);
    csN = 1'b0;
    tick(3);
    startConv();
    finishConv(12'h3C3, 2);
    // R6: read with chip-select high
    csN = 1'b1;
    tick(3);
    rdN = 1'b0;
    tick(5);
    chk("R6 rd ignored int", intN, 0);
    chk("R7 oe off with cs high", dataOe, 0);
    rdN = 1'b1;
    tick(3);
    csN = 1'b0;
    tick(3);
    chk("R6 no late clear", intN, 0);
    readOut();

    // R8: high-speed mode
    fastMode = 1'b1;
    csN = 1'b1;
    tick(2);
    chk("R8 oe latency", dataOe, 0);
    tick(1);
    chk("R8 oe on in fast mode", dataOe, 1);
    csN = 1'b0;
    tick(3);
    startConv();
    finishConv(12'hF0F, 0);
    chk("R8 oe held through conversion", dataOe, 1);
    fastMode = 1'b0;
    tick(3);
    chk("R7 oe off leaving fast mode", dataOe, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #2000000;
    nVec++;
    nBad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule